// File: doc/BRIEF.md
# Presettable Most-Significant-Digit Divide-by-N Counter

A small 4-bit down counter with a parallel preset. It is built to be the top stage of a programmable frequency divider. Each enabled rising clock edge either reloads the counter from the preset inputs or steps it down by one. A combinational flag goes high while the count is zero.

In single-stage use the zero flag is wired back to the load-enable input. The counter then divides the enabled clock by the programmed value N. In a longer divider chain the block sits above lower binary or decimal stages. Those stages, together with a shared zero-detect gate that drives the load enable, are outside the block. The clock enable carries the borrow from the stage below. The block has no borrow-in from a higher stage, so it can only be the most significant digit.

A load reloads the counter with N-1, because the loading edge counts as one of the N periods. The value N = 0 is illegal. Loading it does not wrap the counter through 15. Instead the counter parks at zero and raises an error flag.

Top module: `msd_divn_counter`

## Requirements
- R1: While `rst_ni` is low, the state is reset asynchronously: `count_o` = 0, `zero_o` = 1, `err_o` = 0.
- R2: `zero_o` is 1 exactly when `count_o` equals 0, in the same cycle, with no clock delay.
- R3: On a rising edge with `en_i` = 1, `load_en_i` = 0 and `count_o` nonzero, `count_o` decreases by exactly 1.
- R4: On a rising edge with `en_i` = 1, `load_en_i` = 0 and `count_o` = 0, `count_o` stays 0. It does not wrap to 15.
- R5: On a rising edge with `en_i` = 1, `load_en_i` = 1 and `preset_i` = N in 1..15, `count_o` becomes N-1 and `err_o` clears. The load takes priority over a decrement on the same edge.
- R6: On a rising edge with `en_i` = 1, `load_en_i` = 1 and `preset_i` = 0, `count_o` becomes 0 and `err_o` becomes 1. `err_o` stays 1 until a load with a nonzero preset.
- R7: On a rising edge with `en_i` = 0, `count_o` and `err_o` keep their values, whatever `load_en_i` and `preset_i` are.
- R8: With `load_en_i` tied to `zero_o` and `en_i` held at 1, `zero_o` is high on exactly one of every N consecutive cycles, for N = 1, 5 and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Clock enable; in a chain, the borrow from the lower stage |
| load_en_i | input | 1 | Load enable; reloads the counter from `preset_i` |
| preset_i | input | 4 | Programmed divide value N, unsigned binary; 0 is illegal |
| count_o | output | 4 | Present count |
| zero_o | output | 1 | High while the count is zero |
| err_o | output | 1 | Sticky flag: the last load used N = 0 |

## Verification
The bench goes after the edges where an off-by-one or a wrong priority would show up.
- A decrement from zero: a counter that wraps shows 15 instead of 0.
- A load while the count is nonzero: a design that lets the decrement win shows the old count minus one.
- A load with preset 1: a counter that loads N rather than N-1 fails here, and in closed-loop mode it divides by N+1 instead of N.
- A preset of zero: a design that does not trap it shows 15 and no error flag.
- Load and preset changes while the enable is low: a design that does not gate on the enable changes its count during those cycles.
- Loop mode at N = 1: the zero flag must stay high on every cycle.

// File: rtl/msd_divn_pkg.sv
package msd_divn_pkg;
  localparam int unsigned CNT_W = 4;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_DECR = 2'd1,
    ACT_LOAD = 2'd2,
    ACT_TRAP = 2'd3
  } act_e;
endpackage

// File: rtl/divn_preset_check.sv
module divn_preset_check #(
  parameter int unsigned WIDTH = msd_divn_pkg::CNT_W
) (
  input  logic [WIDTH-1:0] preset_i,
  output logic             illegal_o,
  output logic [WIDTH-1:0] load_val_o
);
  assign illegal_o  = (preset_i == '0);
  // loading edge is the first of N periods, so N-1 remains
  assign load_val_o = preset_i - WIDTH'(1);
endmodule

// File: rtl/divn_step_sel.sv
module divn_step_sel
  import msd_divn_pkg::*;
(
  input  logic en_i,
  input  logic load_en_i,
  input  logic illegal_i,
  input  logic cnt_zero_i,
  output act_e act_o
);
  always_comb begin
    act_o = ACT_HOLD;
    if (en_i) begin
      if (load_en_i)       act_o = illegal_i ? ACT_TRAP : ACT_LOAD;
      else if (!cnt_zero_i) act_o = ACT_DECR;
    end
  end
endmodule

// File: rtl/divn_state_reg.sv
module divn_state_reg
  import msd_divn_pkg::*;
#(
  parameter int unsigned WIDTH = CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  act_e             act_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      err_o <= 1'b0;
    end else begin
      unique case (act_i)
        ACT_DECR: cnt_o <= cnt_o - WIDTH'(1);
        ACT_LOAD: begin
          cnt_o <= load_val_i;
          err_o <= 1'b0;
        end
        ACT_TRAP: begin
          cnt_o <= '0;
          err_o <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/divn_zero_det.sv
module divn_zero_det #(
  parameter int unsigned WIDTH = msd_divn_pkg::CNT_W
) (
  input  logic [WIDTH-1:0] cnt_i,
  output logic             zero_o
);
  logic [WIDTH:0] any_set;
  assign any_set[0] = 1'b0;
  for (genvar b = 0; b < WIDTH; b++) begin : g_or
    assign any_set[b+1] = any_set[b] | cnt_i[b];
  end
  assign zero_o = ~any_set[WIDTH];
endmodule

// File: rtl/msd_divn_counter.sv
module msd_divn_counter
  import msd_divn_pkg::*;
#(
  parameter int unsigned WIDTH = CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_en_i,
  input  logic [WIDTH-1:0] preset_i,
  output logic [WIDTH-1:0] count_o,
  output logic             zero_o,
  output logic             err_o
);
  logic             illegal;
  logic [WIDTH-1:0] load_val;
  act_e             act;

  divn_preset_check #(.WIDTH(WIDTH)) i_check (
    .preset_i  (preset_i),
    .illegal_o (illegal),
    .load_val_o(load_val)
  );

  divn_step_sel i_sel (
    .en_i      (en_i),
    .load_en_i (load_en_i),
    .illegal_i (illegal),
    .cnt_zero_i(zero_o),
    .act_o     (act)
  );

  divn_state_reg #(.WIDTH(WIDTH)) i_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act),
    .load_val_i(load_val),
    .cnt_o     (count_o),
    .err_o     (err_o)
  );

  divn_zero_det #(.WIDTH(WIDTH)) i_zero (
    .cnt_i (count_o),
    .zero_o(zero_o)
  );
endmodule

// File: rtl/msd_divn_counter_chk.sv
module msd_divn_counter_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             load_en_i,
  input logic [WIDTH-1:0] preset_i,
  input logic [WIDTH-1:0] count_o,
  input logic             zero_o,
  input logic             err_o
);
  AST_RESET_STATE: assert property (@(posedge clk_i) !rst_ni |-> (count_o == '0 && !err_o)); // R1
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni) zero_o == (count_o == '0)); // R2
  AST_DECR_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni) (en_i && !load_en_i && count_o != '0) |=> count_o == WIDTH'($past(count_o) - WIDTH'(1))); // R3
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni) (en_i && !load_en_i && count_o == '0) |=> count_o == '0); // R4
  AST_LOAD_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni) (en_i && load_en_i && preset_i != '0) |=> (count_o == WIDTH'($past(preset_i) - WIDTH'(1)) && !err_o)); // R5
  AST_LOAD_ZERO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni) (en_i && load_en_i && preset_i == '0) |=> (count_o == '0 && err_o)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) (err_o && !(en_i && load_en_i)) |=> err_o); // R6
  AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni) !en_i |=> ($stable(count_o) && $stable(err_o))); // R7
endmodule

bind msd_divn_counter msd_divn_counter_chk #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_msd_divn_counter.sv
module test_msd_divn_counter;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {en, load_en, preset[3:0], exp_count[3:0], exp_err}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 4'd5,  4'd4,  1'b0},  // R5 load 5 -> 4
    {1'b1, 1'b0, 4'd0,  4'd3,  1'b0},  // R3 decrement
    {1'b0, 1'b1, 4'd9,  4'd3,  1'b0},  // R7 disabled load ignored
    {1'b1, 1'b0, 4'd0,  4'd2,  1'b0},  // R3
    {1'b1, 1'b1, 4'd12, 4'd11, 1'b0},  // R5 load beats decrement
    {1'b1, 1'b1, 4'd1,  4'd0,  1'b0},  // R5 N=1 -> 0, R2 zero high
    {1'b1, 1'b0, 4'd0,  4'd0,  1'b0},  // R4 no wrap
    {1'b1, 1'b1, 4'd0,  4'd0,  1'b1},  // R6 illegal preset
    {1'b1, 1'b0, 4'd0,  4'd0,  1'b1},  // R6 sticky
    {1'b0, 1'b1, 4'd7,  4'd0,  1'b1},  // R7 disabled, err kept
    {1'b1, 1'b1, 4'd15, 4'd14, 1'b0},  // R5 legal load clears err
    {1'b1, 1'b0, 4'd0,  4'd13, 1'b0}   // R3
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       pe_drv = 1'b0;
  logic       loop_mode = 1'b0;
  logic [3:0] preset_i = 4'd0;
  logic [3:0] count_o;
  logic       zero_o, err_o;
  logic       load_en_i;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  assign load_en_i = loop_mode ? zero_o : pe_drv;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  msd_divn_counter i_msd_divn_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .load_en_i(load_en_i),
    .preset_i(preset_i), .count_o(count_o), .zero_o(zero_o), .err_o(err_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    en_i = 1'b0;
    pe_drv = 1'b0;
    #1;
    chk("R1", "count in reset", int'(count_o), 0);
    chk("R1", "zero in reset", int'(zero_o), 1);
    chk("R1", "err in reset", int'(err_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic run_loop(input int n, input int periods);
    int zeros = 0;
    do_reset();
    preset_i = 4'(n);
    loop_mode = 1'b1;
    en_i = 1'b1;
    for (int c = 0; c < n * periods; c++) begin
      @(negedge clk_i);
      if (zero_o) zeros++;
    end
    chk("R8", $sformatf("zero pulses N=%0d", n), zeros, periods);
    loop_mode = 1'b0;
    en_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    do_reset();
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk_i);
      en_i = VEC[v][10];
      pe_drv = VEC[v][9];
      preset_i = VEC[v][8:5];
      @(posedge clk_i);
      #1;
      chk($sformatf("vec%0d", v), "count", int'(count_o), int'(VEC[v][4:1]));
      chk($sformatf("vec%0d", v), "err", int'(err_o), int'(VEC[v][0]));
      chk($sformatf("vec%0d R2", v), "zero", int'(zero_o), int'(VEC[v][4:1] == 4'd0));
    end
    // R1: asynchronous reset mid-count
    @(negedge clk_i);
    en_i = 1'b0;
    #2 rst_ni = 1'b0;
    #1;
    chk("R1", "async reset count", int'(count_o), 0);
    chk("R1", "async reset zero", int'(zero_o), 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_loop(5, 4);
    run_loop(1, 6);
    run_loop(15, 2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule